// File: doc/BRIEF.md
# MDIO Management Master Controller

This block lets a host reach the management registers of an Ethernet PHY over the two-wire MDC/MDIO interface. The host sees two 16-bit registers. A control word holds the PHY address, the register number, a clock-range code, a direction flag and a busy flag. A data word holds the value to be written, or the value returned by a read.

Writing the control word with busy set launches one Clause 22 frame. The controller divides the system clock down to MDC. It shifts the frame out MSB first and changes MDIO only while MDC is low. On a read it lets go of the line at the turnaround and samples the PHY's reply on MDC rising edges.

The host polls busy until it clears. The register port is a plain strobe port with no back-pressure: a write that lands while a frame is in flight is dropped.

Top module: `mdio_master_ctrl`

## Requirements
- R1: After reset both registers read 0, MDC is low and the MDIO output enable is low.
- R2: A control-word write (reg_sel=0) with bit 0 set, made while idle, starts a frame. Bit 0 then reads 1 on the next cycle and clears by itself once the 64th MDC period has ended.
- R3: With bit 1 of the control word set, the frame is a write. It is sent MSB first and MDIO is driven throughout. The frame is: 32 ones, then 01, then opcode 01, then the PHY address (control bits 15:11), then the register number (control bits 10:6), then turnaround 10, then the 16 bits held in the data word.
- R4: With bit 1 clear, the frame is a read with opcode 10. When busy clears, the data word (reg_sel=1) holds the 16 bits sampled from mdio_i on the rising MDC edges of frame bits 48 to 63, MSB first.
- R5: During a read, mdio_oe is low from frame bit 46 (the first turnaround bit) to the end of the frame. It is also low whenever no frame is running.
- R6: Control bits 4:2 select the MDC period in system clocks: code 0 gives 42, 1 gives 62, 2 gives 16, 3 gives 26, 4 gives 102, and 5, 6 and 7 give 124.
- R7: A control-word write made while busy reads 1 has no effect on the register contents or on the frame in flight.
- R8: A data-word write made while busy reads 1 has no effect.
- R9: A control-word read returns the live busy state in bit 0 and the last accepted written value in bits 15:1.
- R10: MDC stays low while no frame is running, and mdio_o changes only while MDC is low.
- R11: A control-word write made while idle with bit 0 clear stores bits 15:1 and starts no frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Register select: 0 control word, 1 data word |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 16 | Write value |
| reg_rdata | output | 16 | Read value of the selected register (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_i | input | 1 | MDIO line as seen at the pad |
| mdio_o | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO drive enable (0 releases the line) |

## Verification
The assertions assume three things about the inputs. The host raises reg_wr for single cycles. reg_sel is valid whenever reg_wr is high. mdio_i is settled before each MDC rising edge, so it is stable in the system-clock cycle where the controller samples it. The bench drives every register access between clock edges. Its PHY model changes mdio_i only on MDC falling edges, which is half an MDC period before the controller samples. Where the line is released and nobody drives it, the bench models a pull-up by reading it as 1.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int PREAMBLE_LEN = 32;
  localparam int ADDR_W       = 5;
  localparam int DATA_W       = 16;
  // start(2) + op(2) + phy + reg + turnaround(2) + data
  localparam int FRAME_BITS   = PREAMBLE_LEN + 6 + 2 * ADDR_W + DATA_W;
  localparam int TA_POS       = PREAMBLE_LEN + 4 + 2 * ADDR_W;
  localparam int DATA_POS     = TA_POS + 2;

  // control word bits 15:1, MSB first
  typedef struct packed {
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regn;
    logic              spare;
    logic [2:0]        clk_sel;
    logic              wr;
  } ctrl_t;

  function automatic int unsigned mdc_ratio(input logic [2:0] code);
    case (code)
      3'd0:    return 42;
      3'd1:    return 62;
      3'd2:    return 16;
      3'd3:    return 26;
      3'd4:    return 102;
      default: return 124;
    endcase
  endfunction

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] ratio,
  output logic             mdc,
  output logic             rise_stb,
  output logic             fall_stb
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] half;

  assign half     = ratio >> 1;
  assign rise_stb = run && (cnt == half - 1'b1);
  assign fall_stb = run && (cnt == ratio - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (fall_stb) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
      if (rise_stb) mdc <= 1'b1;
    end
  end

  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < ratio));

  // R6
  rise_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |=> mdc);

endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
  import mdio_pkg::*;
#(
  parameter int NBITS = FRAME_BITS,
  parameter int DW    = DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NBITS-1:0] frame_in,
  input  logic             is_read,
  input  logic             rise_stb,
  input  logic             fall_stb,
  input  logic             mdc,
  input  logic             mdio_i,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic [DW-1:0]    rd_data,
  output logic             done
);

  localparam int IDX_W = $clog2(NBITS + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBITS - 1);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_POS);
  localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(DATA_POS);

  logic             active;
  logic             rd_q;
  logic [NBITS-1:0] sr;
  logic [IDX_W-1:0] idx;

  assign done    = active && fall_stb && (idx == LAST_IDX);
  assign mdio_oe = active && !(rd_q && idx >= TA_IDX);
  assign mdio_o  = mdio_oe && sr[NBITS-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      rd_q    <= 1'b0;
      sr      <= '0;
      idx     <= '0;
      rd_data <= '0;
    end else if (start) begin
      active <= 1'b1;
      rd_q   <= is_read;
      sr     <= frame_in;
      idx    <= '0;
    end else if (active) begin
      if (rise_stb && rd_q && idx >= DAT_IDX)
        rd_data <= {rd_data[DW-2:0], mdio_i};
      if (fall_stb) begin
        if (idx == LAST_IDX) begin
          active <= 1'b0;
        end else begin
          idx <= idx + 1'b1;
          sr  <= sr << 1;
        end
      end
    end
  end

  // R5
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && rd_q && idx >= TA_IDX) |-> !mdio_oe);

  // R10
  mdio_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_o) |-> !mdc);

endmodule

// File: rtl/mdio_master_ctrl.sv
module mdio_master_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_sel,
  input  logic        reg_wr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe
);

  ctrl_t                  ctrl_q;
  ctrl_t                  ctrl_new;
  logic                   busy_q;
  logic [DATA_W-1:0]      data_q;
  logic                   ctrl_wr_ok;
  logic                   launch;
  logic                   done;
  logic                   rise_stb;
  logic                   fall_stb;
  logic [DATA_W-1:0]      rd_data;
  logic [FRAME_BITS-1:0]  frame;
  logic [DIV_W-1:0]       ratio;

  assign ctrl_new   = ctrl_t'(reg_wdata[15:1]);
  assign ctrl_wr_ok = reg_wr && !reg_sel && !busy_q;
  assign launch     = ctrl_wr_ok && reg_wdata[0];
  assign ratio      = DIV_W'(mdc_ratio(ctrl_q.clk_sel));

  always_comb begin
    frame = {{PREAMBLE_LEN{1'b1}}, 2'b01,
             ctrl_new.wr ? 2'b01 : 2'b10,
             ctrl_new.phy, ctrl_new.regn,
             ctrl_new.wr ? 2'b10 : 2'b11,
             ctrl_new.wr ? data_q : {DATA_W{1'b1}}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      busy_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (ctrl_wr_ok) ctrl_q <= ctrl_new;
      if (launch)    busy_q <= 1'b1;
      else if (done) busy_q <= 1'b0;
      if (done && !ctrl_q.wr)
        data_q <= rd_data;
      else if (reg_wr && reg_sel && !busy_q)
        data_q <= reg_wdata;
    end
  end

  assign reg_rdata = reg_sel ? data_q : {ctrl_q, busy_q};

  mdio_clk_div #(.DIV_W(DIV_W)) i_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy_q),
    .ratio    (ratio),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_frame_shifter i_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (launch),
    .frame_in (frame),
    .is_read  (!ctrl_new.wr),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .mdc      (mdc),
    .mdio_i   (mdio_i),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .rd_data  (rd_data),
    .done     (done)
  );

  // R2
  busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q);

  // R7
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && reg_wr && !reg_sel) |=> (ctrl_q == $past(ctrl_q)));

  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && reg_wr && reg_sel && !done) |=> (data_q == $past(data_q)));

  // R10
  mdc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !mdc);

  // R5
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !mdio_oe);

endmodule

// File: tb/test_mdio_master_ctrl.sv
`timescale 1ns/1ps
module test_mdio_master_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, line;
  logic        phy_en = 1'b0;
  logic        phy_bit = 1'b1;
  logic [15:0] phy_val = '0;
  logic        phy_rd_mode = 1'b0;
  int          k = 0;
  logic [63:0] cap = '0;
  logic [63:0] oe_rec = '0;
  int          checks = 0;
  int          errors = 0;

  always #2 clk = ~clk;

  assign line = mdio_oe ? mdio_o : (phy_en ? phy_bit : 1'b1);

  mdio_master_ctrl i_mdio_master_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_i(line), .mdio_o(mdio_o), .mdio_oe(mdio_oe));

  // PHY model: capture on rising MDC, drive on falling MDC
  always @(posedge mdc) begin
    if (k < 64) begin
      cap[63-k]    = line;
      oe_rec[63-k] = mdio_oe;
    end
    k = k + 1;
  end

  always @(negedge mdc) begin
    if (phy_rd_mode && k >= 47 && k < 64) begin
      phy_en  = 1'b1;
      phy_bit = (k == 47) ? 1'b0 : phy_val[15-(k-48)];
    end else begin
      phy_en = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [15:0] val);
    @(negedge clk);
    reg_sel = sel; reg_wdata = val; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [15:0] val);
    @(negedge clk);
    reg_sel = sel;
    #0.5 val = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    int n = 0;
    do begin
      rd(1'b0, v);
      n++;
    end while (v[0] && n < 20000);
  endtask

  function automatic logic [63:0] exp_frame(input bit w, input logic [4:0] p,
                                            input logic [4:0] r, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (w ? 2'b01 : 2'b10), p, r,
            (w ? 2'b10 : 2'b11), (w ? d : 16'hFFFF)};
  endfunction

  function automatic logic [15:0] cword(input logic [4:0] p, input logic [4:0] r,
                                        input logic [2:0] c, input bit w, input bit go);
    return {p, r, 1'b0, c, w, go};
  endfunction

  task automatic t_reset();
    logic [15:0] v;
    rd(1'b0, v); check(v == 0, "R1 ctrl", v, 0);
    rd(1'b1, v); check(v == 0, "R1 data", v, 0);
    check(!mdc && !mdio_oe, "R1 pins", {mdc, mdio_oe}, 0);
  endtask

  task automatic t_store_only();
    logic [15:0] v;
    bit saw = 0;
    wr(1'b0, 16'hFFFE);
    rd(1'b0, v); check(v == 16'hFFFE, "R11 stored no start", v, 16'hFFFE);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (mdc || mdio_oe) saw = 1;
    end
    check(!saw, "R10 mdc idle low", saw, 0);
    rd(1'b0, v); check(v == 16'hFFFE, "R9 readback all fields", v, 16'hFFFE);
  endtask

  task automatic t_write_frame();
    logic [15:0] v, cw;
    cw = cword(5'h13, 5'h0A, 3'd2, 1, 1);
    wr(1'b1, 16'hA5C3);
    k = 0; phy_rd_mode = 0;
    wr(1'b0, cw);
    rd(1'b0, v); check(v == cw, "R2 busy set, R9 fields", v, cw);
    wr(1'b0, cword(5'h01, 5'h02, 3'd0, 0, 1));
    wr(1'b1, 16'h1111);
    wait_idle();
    check(cap == exp_frame(1, 5'h13, 5'h0A, 16'hA5C3), "R3 write frame", cap,
          exp_frame(1, 5'h13, 5'h0A, 16'hA5C3));
    check(&oe_rec, "R3 driven throughout", oe_rec, 64'hFFFF_FFFF_FFFF_FFFF);
    check(k == 64, "R2 frame length", k, 64);
    rd(1'b0, v); check(v == {cw[15:1], 1'b0}, "R7 ctrl write ignored, R2 clear", v, {cw[15:1], 1'b0});
    rd(1'b1, v); check(v == 16'hA5C3, "R8 data write ignored", v, 16'hA5C3);
    check(!mdc, "R10 mdc low after frame", mdc, 0);
  endtask

  task automatic t_read(input logic [4:0] p, input logic [4:0] r, input logic [15:0] pv);
    logic [15:0] v;
    k = 0; phy_rd_mode = 1; phy_val = pv;
    wr(1'b0, cword(p, r, 3'd2, 0, 1));
    wait_idle();
    phy_rd_mode = 0;
    check(cap[63:18] == exp_frame(0, p, r, 0) >> 18, "R4 read header", cap[63:18],
          exp_frame(0, p, r, 0) >> 18);
    check(oe_rec[63:18] == {46{1'b1}} && oe_rec[17:0] == 0, "R5 release at turnaround",
          oe_rec, {{46{1'b1}}, 18'h0});
    rd(1'b1, v); check(v == pv, "R4 read data", v, pv);
    check(!mdio_oe, "R5 idle released", mdio_oe, 0);
  endtask

  task automatic t_ratio(input logic [2:0] code, input int expn);
    realtime t0, t1;
    int per;
    k = 0; phy_rd_mode = 0;
    wr(1'b0, cword(5'h02, 5'h03, code, 1, 1));
    @(posedge mdc); @(posedge mdc); t0 = $realtime;
    @(posedge mdc); t1 = $realtime;
    per = int'((t1 - t0) / 4.0);
    check(per == expn, $sformatf("R6 code %0d period", code), per, expn);
    wait_idle();
  endtask

  initial begin
    #600000;
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_store_only();
    t_write_frame();
    t_read(5'h1F, 5'h00, 16'h3C5A);
    t_read(5'h00, 5'h1F, 16'h8001);
    t_ratio(3'd0, 42);
    t_ratio(3'd1, 62);
    t_ratio(3'd2, 16);
    t_ratio(3'd3, 26);
    t_ratio(3'd4, 102);
    t_ratio(3'd5, 124);
    t_ratio(3'd6, 124);
    t_ratio(3'd7, 124);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule